// File: doc/BRIEF.md
# Pixel Black-Level Clamp and Blanking Output Stage

This block sits directly after a 12-bit pixel converter and conditions its output codes. It runs a digital black-level loop once per line: during a clamp window, which normally covers the shielded black pixels, it compares the corrected pixel against a programmable 8-bit target. It then moves a signed correction value through a first-order, shift-scaled accumulator. The correction is subtracted from every later pixel. Pixels inside a preblank window are forced to zero. Every result leaves the block through a fixed nine-stage delay line.

Software may turn the loop off. In that case the target level is added to each pixel as a fixed offset, and the stored correction is frozen. One polarity input selects whether both strobes are active-high or active-low. When both strobes are active together, the clamp strobe takes precedence over blanking.

Top module: `blkc_output_stage`

## Requirements
- R1: While `rst_n` is low, the correction value is zero and `pix_out` is zero. In the first eight cycles after release, `pix_out` stays zero because the delay line is flushed. The first pixels after reset are corrected by zero.
- R2: A pixel sampled on rising edge n produces its result on `pix_out` after rising edge n+8 (nine register stages), and the result holds until edge n+9.
- R3: With `loop_en`=0, the output is min(pixel + `target_lvl`, 4095). A clamp strobe leaves the stored correction unchanged, so it still applies once the loop is turned back on.
- R4: With `loop_en`=1, the output is pixel minus correction, clipped to the range 0 to 4095.
- R5: With `loop_en`=1 and the clamp strobe active, the correction is updated on each edge to corr + floor(err / 2^SHIFT), where err = pixel − corr − target and SHIFT defaults to 2. The output for that same pixel uses the correction from before the update.
- R6: The correction is a signed value of CORR_W bits (default 10). It saturates at +511 and −512 and never wraps.
- R7: While the clamp strobe is inactive, the correction is unchanged.
- R8: When the preblank strobe is active and the clamp strobe is not, the output word is zero.
- R9: When both strobes are active, the clamp strobe wins. The output is the normal corrected pixel and the loop updates as in R5.
- R10: With `strobe_pol`=1, both strobes are active when high. With `strobe_pol`=0, both are active when low.
- R11: After 40 or more clamp cycles on a constant black pixel, the corrected black level settles between target and target+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one pixel per rising edge |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously to `clk` |
| pix_in | input | 12 | Raw pixel code from the converter |
| clamp_strobe | input | 1 | Black-level clamp window strobe (polarity set by `strobe_pol`) |
| blank_strobe | input | 1 | Preblank strobe (polarity set by `strobe_pol`) |
| strobe_pol | input | 1 | 1: strobes active-high; 0: strobes active-low |
| loop_en | input | 1 | 1: clamp loop runs; 0: loop frozen and target added as offset |
| target_lvl | input | 8 | Target black level, 0 to 255 LSB |
| pix_out | output | 12 | Conditioned pixel, nine cycles after its input |

## Verification
The checker assumes that `rst_n` is released away from a clock edge and that the configuration inputs (`strobe_pol`, `loop_en`, `target_lvl`) change only between edges. Its step-direction properties also assume that the pixel and target are stable during the cycle in which they are sampled. The bench respects all of these by driving every input, configuration included, on the falling clock edge and releasing reset there. Strobe levels are always derived from the current polarity setting, except in the polarity scenario, which drives raw levels on purpose to show that the inactive level is ignored.

// File: rtl/blkc_pkg.sv
package blkc_pkg;

  // Decoded role of the current pixel after polarity and priority
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_CLAMP = 2'd1,
    MODE_BLANK = 2'd2
  } strobe_mode_e;

  function automatic logic strobe_on(input logic lvl, input logic pol);
    return pol ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/blkc_strobe_decode.sv
module blkc_strobe_decode
  import blkc_pkg::*;
(
  input  logic         clamp_raw,
  input  logic         blank_raw,
  input  logic         pol,
  output strobe_mode_e mode
);

  logic clamp_on;
  logic blank_on;

  always_comb begin
    clamp_on = strobe_on(clamp_raw, pol);
    blank_on = strobe_on(blank_raw, pol);
    // Clamp window has priority over blanking
    if (clamp_on) begin
      mode = MODE_CLAMP;
    end else if (blank_on) begin
      mode = MODE_BLANK;
    end else begin
      mode = MODE_PASS;
    end
  end

endmodule

// File: rtl/blkc_clamp_loop.sv
module blkc_clamp_loop #(
  parameter int PIX_W  = 12,
  parameter int TGT_W  = 8,
  parameter int CORR_W = 10,
  parameter int SHIFT  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         pix,
  input  logic [TGT_W-1:0]         target,
  input  logic                     loop_en,
  input  logic                     win_on,
  output logic signed [CORR_W-1:0] corr
);

  localparam int EW = ((PIX_W > CORR_W) ? PIX_W : CORR_W) + 3;
  localparam logic signed [CORR_W-1:0] C_HI = {1'b0, {(CORR_W-1){1'b1}}};
  localparam logic signed [CORR_W-1:0] C_LO = {1'b1, {(CORR_W-1){1'b0}}};
  localparam logic signed [EW-1:0] CMAX = $signed({{(EW-CORR_W){1'b0}}, C_HI});
  localparam logic signed [EW-1:0] CMIN = $signed({{(EW-CORR_W){1'b1}}, C_LO});

  logic signed [EW-1:0]     pix_x;
  logic signed [EW-1:0]     tgt_x;
  logic signed [EW-1:0]     corr_x;
  logic signed [EW-1:0]     err;
  logic signed [EW-1:0]     step;
  logic signed [EW-1:0]     sum;
  logic signed [EW-1:0]     sat;
  logic signed [CORR_W-1:0] corr_d;
  logic signed [CORR_W-1:0] corr_q;
  logic                     upd_en;

  // Next-state: scaled error accumulated with saturation
  always_comb begin
    pix_x  = $signed({{(EW-PIX_W){1'b0}}, pix});
    tgt_x  = $signed({{(EW-TGT_W){1'b0}}, target});
    corr_x = $signed({{(EW-CORR_W){corr_q[CORR_W-1]}}, corr_q});
    err    = pix_x - corr_x - tgt_x;
    step   = err >>> SHIFT;
    sum    = corr_x + step;
    if (sum > CMAX) begin
      sat = CMAX;
    end else if (sum < CMIN) begin
      sat = CMIN;
    end else begin
      sat = sum;
    end
    corr_d = CORR_W'(sat);
    upd_en = loop_en & win_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
    end else if (upd_en) begin
      corr_q <= corr_d;
    end
  end

  assign corr = corr_q;

endmodule

// File: rtl/blkc_pixel_path.sv
module blkc_pixel_path
  import blkc_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int TGT_W  = 8,
  parameter int CORR_W = 10
) (
  input  logic [PIX_W-1:0]         pix,
  input  logic [TGT_W-1:0]         target,
  input  logic signed [CORR_W-1:0] corr,
  input  logic                     loop_en,
  input  strobe_mode_e             mode,
  output logic [PIX_W-1:0]         val
);

  localparam int EW = ((PIX_W > CORR_W) ? PIX_W : CORR_W) + 3;
  localparam logic [PIX_W-1:0] PTOP = {PIX_W{1'b1}};
  localparam logic signed [EW-1:0] PMAX = $signed({{(EW-PIX_W){1'b0}}, PTOP});

  logic signed [EW-1:0] pix_x;
  logic signed [EW-1:0] tgt_x;
  logic signed [EW-1:0] corr_x;
  logic signed [EW-1:0] raw;
  logic signed [EW-1:0] clip;

  always_comb begin
    pix_x  = $signed({{(EW-PIX_W){1'b0}}, pix});
    tgt_x  = $signed({{(EW-TGT_W){1'b0}}, target});
    corr_x = $signed({{(EW-CORR_W){corr[CORR_W-1]}}, corr});
    // Loop running: subtract tracked correction; frozen: fixed offset
    raw = loop_en ? (pix_x - corr_x) : (pix_x + tgt_x);
    if (raw < 0) begin
      clip = '0;
    end else if (raw > PMAX) begin
      clip = PMAX;
    end else begin
      clip = raw;
    end
    val = (mode == MODE_BLANK) ? '0 : PIX_W'(clip);
  end

endmodule

// File: rtl/blkc_delay_line.sv
module blkc_delay_line #(
  parameter int W     = 12,
  parameter int DEPTH = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] first_q,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_d [DEPTH];
  logic [W-1:0] stg_q [DEPTH];

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign stg_d[gi] = din;
      end else begin : g_body
        assign stg_d[gi] = stg_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign first_q = stg_q[0];
  assign dout    = stg_q[DEPTH-1];

endmodule

// File: rtl/blkc_output_stage.sv
module blkc_output_stage
  import blkc_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int TGT_W   = 8,
  parameter int CORR_W  = 10,
  parameter int SHIFT   = 2,
  parameter int LATENCY = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             clamp_strobe,
  input  logic             blank_strobe,
  input  logic             strobe_pol,
  input  logic             loop_en,
  input  logic [TGT_W-1:0] target_lvl,
  output logic [PIX_W-1:0] pix_out
);

  strobe_mode_e             mode;
  logic                     win_on;
  logic signed [CORR_W-1:0] corr;
  logic [PIX_W-1:0]         cond_val;
  logic [PIX_W-1:0]         stage0;

  blkc_strobe_decode u_decode (
    .clamp_raw (clamp_strobe),
    .blank_raw (blank_strobe),
    .pol       (strobe_pol),
    .mode      (mode)
  );

  assign win_on = (mode == MODE_CLAMP);

  blkc_clamp_loop #(
    .PIX_W  (PIX_W),
    .TGT_W  (TGT_W),
    .CORR_W (CORR_W),
    .SHIFT  (SHIFT)
  ) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix     (pix_in),
    .target  (target_lvl),
    .loop_en (loop_en),
    .win_on  (win_on),
    .corr    (corr)
  );

  blkc_pixel_path #(
    .PIX_W  (PIX_W),
    .TGT_W  (TGT_W),
    .CORR_W (CORR_W)
  ) u_path (
    .pix     (pix_in),
    .target  (target_lvl),
    .corr    (corr),
    .loop_en (loop_en),
    .mode    (mode),
    .val     (cond_val)
  );

  blkc_delay_line #(
    .W     (PIX_W),
    .DEPTH (LATENCY)
  ) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (cond_val),
    .first_q (stage0),
    .dout    (pix_out)
  );

endmodule

// File: rtl/blkc_output_stage_chk.sv
module blkc_output_stage_chk
  import blkc_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int TGT_W  = 8,
  parameter int CORR_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PIX_W-1:0]         pix_in,
  input logic [TGT_W-1:0]         target_lvl,
  input logic                     loop_en,
  input logic                     clamp_strobe,
  input logic                     strobe_pol,
  input strobe_mode_e             mode,
  input logic signed [CORR_W-1:0] corr,
  input logic [PIX_W-1:0]         stage0,
  input logic [PIX_W-1:0]         pix_out
);

  localparam int EW = ((PIX_W > CORR_W) ? PIX_W : CORR_W) + 3;
  localparam logic signed [CORR_W-1:0] C_HI = {1'b0, {(CORR_W-1){1'b1}}};
  localparam logic signed [CORR_W-1:0] C_LO = {1'b1, {(CORR_W-1){1'b0}}};

  logic signed [EW-1:0] err_c;
  logic                 clamp_lvl_on;

  always_comb begin
    err_c = $signed({{(EW-PIX_W){1'b0}}, pix_in})
          - $signed({{(EW-CORR_W){corr[CORR_W-1]}}, corr})
          - $signed({{(EW-TGT_W){1'b0}}, target_lvl});
    clamp_lvl_on = strobe_pol ? clamp_strobe : ~clamp_strobe;
  end

  // R1
  always @(posedge clk) begin
    rst_clear_chk: assert (rst_n || (corr == '0 && pix_out == '0))
      else $error("correction or output not cleared in reset");
  end

  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> $stable(corr));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_CLAMP) |=> $stable(corr));

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && mode == MODE_CLAMP && err_c >= 4 && corr != C_HI) |=> (corr > $past(corr)));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && mode == MODE_CLAMP && err_c < 0 && corr != C_LO) |=> (corr < $past(corr)));

  // R6
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (corr == C_HI && loop_en && mode == MODE_CLAMP && err_c > 0) |=> (corr == C_HI));

  // R8
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BLANK) |=> (stage0 == '0));

  // R9
  clamp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_lvl_on |-> (mode == MODE_CLAMP));

endmodule

bind blkc_output_stage blkc_output_stage_chk #(
  .PIX_W  (PIX_W),
  .TGT_W  (TGT_W),
  .CORR_W (CORR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_in       (pix_in),
  .target_lvl   (target_lvl),
  .loop_en      (loop_en),
  .clamp_strobe (clamp_strobe),
  .strobe_pol   (strobe_pol),
  .mode         (mode),
  .corr         (corr),
  .stage0       (stage0),
  .pix_out      (pix_out)
);

// File: tb/blkc_output_stage_tb.sv
module blkc_output_stage_tb;

  logic        clk;
  logic        rst_n;
  logic [11:0] pix_in;
  logic        clamp_in;
  logic        blank_in;
  logic        pol;
  logic        loop_en;
  logic [7:0]  tgt;
  logic [11:0] pix_out;

  int n_chk;
  int n_fail;
  int ecnt;
  int m_corr;
  bit done;

  logic [11:0] exp_q [16];
  string       tag_q [16];
  bit          vld_q [16];

  blkc_output_stage u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_in       (pix_in),
    .clamp_strobe (clamp_in),
    .blank_strobe (blank_in),
    .strobe_pol   (pol),
    .loop_en      (loop_en),
    .target_lvl   (tgt),
    .pix_out      (pix_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic lv(input bit act);
    return pol ? act : !act;
  endfunction

  // Reference model written from the requirements
  function automatic int m_out(input int p, input bit ca, input bit ba);
    int v;
    v = loop_en ? (p - m_corr) : (p + int'(tgt));
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    if (ba && !ca) v = 0;
    return v;
  endfunction

  task automatic m_upd(input int p, input bit ca);
    if (loop_en && ca) begin
      int e;
      int st;
      e  = p - m_corr - int'(tgt);
      st = (e >= 0) ? (e / 4) : -((3 - e) / 4);
      m_corr = m_corr + st;
      if (m_corr > 511) m_corr = 511;
      if (m_corr < -512) m_corr = -512;
    end
  endtask

  task automatic drive(input int p, input logic cr, input logic br, input string tag);
    int  e;
    bit  ca;
    bit  ba;
    e  = ecnt;
    ca = pol ? cr : !cr;
    ba = pol ? br : !br;
    pix_in   = 12'(p);
    clamp_in = cr;
    blank_in = br;
    exp_q[e % 16] = 12'(m_out(p, ca, ba));
    tag_q[e % 16] = tag;
    vld_q[e % 16] = 1'b1;
    m_upd(p, ca);
    @(posedge clk);
    ecnt++;
    @(negedge clk);
    if (e < 8) begin
      chk(pix_out == 12'd0, "R1 flushed delay line", int'(pix_out), 0);
    end else if (vld_q[(e - 8) % 16]) begin
      chk(pix_out == exp_q[(e - 8) % 16], tag_q[(e - 8) % 16],
          int'(pix_out), int'(exp_q[(e - 8) % 16]));
      vld_q[(e - 8) % 16] = 1'b0;
    end
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) drive(0, lv(0), lv(0), "R2 flush");
  endtask

  task automatic t_reset();
    rst_n    = 1'b0;
    pix_in   = 12'd0;
    clamp_in = lv(0);
    blank_in = lv(0);
    repeat (2) @(negedge clk);
    chk(pix_out == 12'd0, "R1 output in reset", int'(pix_out), 0);
    ecnt   = 0;
    m_corr = 0;
    for (int i = 0; i < 16; i++) vld_q[i] = 1'b0;
    rst_n = 1'b1;
    // R1: correction starts at zero
    drive(500, lv(0), lv(0), "R1 zero correction");
    flush(9);
  endtask

  task automatic t_latency();
    loop_en = 1'b0;
    tgt     = 8'd0;
    drive(0, lv(0), lv(0), "R2");
    drive(1234, lv(0), lv(0), "R2 impulse");
    drive(0, lv(0), lv(0), "R2");
    drive(7, lv(0), lv(0), "R2");
    drive(4095, lv(0), lv(0), "R2");
    flush(9);
  endtask

  task automatic t_bypass();
    loop_en = 1'b0;
    tgt     = 8'd100;
    drive(10, lv(0), lv(0), "R3 offset");
    drive(4050, lv(0), lv(0), "R3 clip high");
    for (int i = 0; i < 5; i++) drive(3000, lv(1), lv(0), "R3 clamp ignored");
    loop_en = 1'b1;
    drive(200, lv(0), lv(0), "R3 correction untouched");
    flush(9);
  endtask

  task automatic t_converge();
    loop_en = 1'b1;
    tgt     = 8'd64;
    for (int i = 0; i < 40; i++) drive(300, lv(1), lv(0), "R5 clamp update");
    drive(300, lv(0), lv(0), "R11 settled");
    drive(1000, lv(0), lv(0), "R4 corrected");
    drive(50, lv(0), lv(0), "R4 clip low");
    for (int i = 0; i < 6; i++) drive(300 + i, lv(0), lv(0), "R7 hold");
    // pix_out now carries the settled black pixel
    chk(pix_out >= 12'd64 && pix_out <= 12'd67, "R11 black within target+3", int'(pix_out), 64);
    for (int i = 0; i < 4; i++) drive(800, lv(0), lv(0), "R7 hold");
    flush(9);
  endtask

  task automatic t_blank_overlap();
    loop_en = 1'b1;
    tgt     = 8'd32;
    drive(999, lv(0), lv(1), "R8 blanked");
    drive(2000, lv(0), lv(1), "R8 blanked");
    for (int i = 0; i < 6; i++) drive(280, lv(1), lv(1), "R9 clamp wins");
    drive(280, lv(0), lv(0), "R9 loop ran during overlap");
    flush(9);
  endtask

  task automatic t_polarity();
    pol     = 1'b1;
    loop_en = 1'b1;
    tgt     = 8'd64;
    drive(0, 1'b0, 1'b0, "R10 low inactive");
    for (int i = 0; i < 5; i++) drive(500, 1'b1, 1'b0, "R10 high clamp");
    drive(500, 1'b0, 1'b0, "R10 pass");
    drive(700, 1'b0, 1'b1, "R10 high blank");
    drive(700, 1'b0, 1'b0, "R10 pass");
    flush(9);
    pol = 1'b0;
    drive(900, 1'b1, 1'b1, "R10 high inactive");
    drive(900, 1'b1, 1'b0, "R10 low blank");
    flush(9);
  endtask

  task automatic t_saturate();
    loop_en = 1'b1;
    tgt     = 8'd0;
    for (int i = 0; i < 3; i++) drive(4095, lv(1), lv(0), "R6 drive to limit");
    drive(4095, lv(0), lv(0), "R6 saturated +511");
    drive(300, lv(0), lv(0), "R4 clip low");
    tgt = 8'd255;
    for (int i = 0; i < 60; i++) drive(0, lv(1), lv(0), "R5 negative steps");
    drive(4000, lv(0), lv(0), "R4 clip high");
    flush(9);
  endtask

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    ecnt     = 0;
    m_corr   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    pol      = 1'b0;
    loop_en  = 1'b1;
    tgt      = 8'd128;
    pix_in   = 12'd0;
    clamp_in = 1'b1;
    blank_in = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_bypass();
    t_converge();
    t_blank_overlap();
    t_polarity();
    t_reset();
    t_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule